// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records when edges occur on one input pin. It samples the pin through a two-flop synchronizer and compares each synchronized sample with the one before it to find rising and falling edges. When an edge that the selected mode counts is found, the block takes the current value of one of two free-running 16-bit timers and stores it in a four-entry queue. Software drains the queue through a read port. The timers, the bus interface and power management sit outside the block.

The read side is a stream. `rd_valid` is high while the queue holds at least one timestamp, so it also serves as the buffer-not-empty flag. `rd_data` always shows the oldest entry and holds steady until a transfer completes. A transfer happens on a clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` may stay high, and it is ignored while `rd_valid` is low. The capture side cannot push back on the pin. When the queue cannot accept an event, the event is lost, and the lost-event rules below say whether the overflow flag records it.

An interrupt pulse is raised after a programmable number of stored captures, or on every edge in the both-edges mode. A separate rising-edge-only mode turns the pin into a plain interrupt and wake source.

Top module: `edge_stamp_unit`

## Requirements
- R1: The pin passes through two synchronizer flops and one previous-sample flop. If the pin changes between two clock edges, the timestamp, `rd_valid` and `irq_pulse` all change after the third rising clock edge that follows. The stored value is the timer value present during the cycle just before that third edge.
- R2: When `cfg_tsel` is 1 the block samples `timer_a`. When it is 0 the block samples `timer_b`, so a control register reset to zero selects the second timer.
- R3: `cfg_mode` values: 3'b001 captures on both edges, 3'b010 on falling edges only, and 3'b011 on rising edges only.
- R4: Mode 3'b100 captures only every 4th rising edge and mode 3'b101 only every 16th rising edge. A shared rising-edge prescaler counts from zero for this purpose.
- R5: `cfg_mode` 3'b000 or 3'b110 turns the channel off. While it is off, the block clears the prescaler and the interrupt counter, empties the queue, drops `ovf_flag` and captures nothing.
- R6: The queue holds four timestamps and returns them oldest first. `rd_valid` is high exactly when the queue is not empty, and it is low after reset.
- R7: Asserting `rd_ready` while `rd_valid` is low changes nothing: `rd_valid` and `ovf_flag` keep their values.
- R8: The overflow rule applies outside mode 3'b001. A capture that arrives while four entries are stored sets `ovf_flag` and is dropped. Every later capture is also dropped until the queue has been read empty. The read that empties the queue clears `ovf_flag`.
- R9: In mode 3'b001, `irq_pulse` fires on every edge and `cfg_irq_every` is ignored. A capture that meets a full queue is dropped without setting `ovf_flag` and without blocking later captures.
- R10: In modes 3'b010 through 3'b101, `irq_pulse` is a one-cycle pulse after every N stored captures, where N = `cfg_irq_every` + 1. Dropped captures are not counted.
- R11: In mode 3'b111, each rising edge gives an `irq_pulse` and stores nothing. `wake_req` pulses with it when `cfg_irq_en` is 1.
- R12: `wake_req` stays low in every mode other than 3'b111, whatever the value of `cfg_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_async | input | 1 | Monitored pin, asynchronous to clk |
| timer_a | input | 16 | First timebase value |
| timer_b | input | 16 | Second timebase value (default selection) |
| cfg_mode | input | 3 | Capture mode |
| cfg_tsel | input | 1 | Timer select: 1 picks timer_a, 0 picks timer_b |
| cfg_irq_every | input | 2 | Interrupt after this value plus one stored captures |
| cfg_irq_en | input | 1 | Interrupt enable, used to qualify the wake request |
| rd_data | output | 16 | Oldest stored timestamp |
| rd_valid | output | 1 | Queue not empty; rd_data is valid |
| rd_ready | input | 1 | Consumer takes rd_data when rd_valid is high |
| ovf_flag | output | 1 | Capture lost on a full queue; set until the queue is drained |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| wake_req | output | 1 | One-cycle wake request in mode 3'b111 |

## Verification
The assertions check some rules on every cycle. The queue never grows while the overflow lock is set. The overflow flag rises only from a full queue and never rises in both-edges mode. The prescaler reads zero after any cycle with the channel off. A wake request always comes with an interrupt, and only from the wake mode with the enable set. Other behaviour is visible only over a sequence of events, so only the bench scenarios show it: the exact three-edge latency, which timer value lands in each entry, the 4th and 16th edge counting (including the restart after a disable), the every-N interrupt spacing, and that nothing is stored while the lock holds or after a full drain is allowed again.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
  typedef enum logic [2:0] {
    MODE_OFF    = 3'b000,
    MODE_BOTH   = 3'b001,
    MODE_FALL   = 3'b010,
    MODE_RISE   = 3'b011,
    MODE_RISE4  = 3'b100,
    MODE_RISE16 = 3'b101,
    MODE_RSVD   = 3'b110,
    MODE_WAKE   = 3'b111
  } cap_mode_e;
endpackage

// File: rtl/es_pin_sync.sv
module es_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/es_event_gen.sv
module es_event_gen
  import edge_stamp_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cap_mode_e mode,
  input  logic      rise,
  input  logic      fall,
  output logic      cap_req,
  output logic      chan_off,
  output logic      every_edge,
  output logic      wake_mode
);
  localparam int Q4_BITS = 2;

  logic [PRE_W-1:0] presc_q;
  logic             presc_mode;

  assign chan_off   = (mode == MODE_OFF) || (mode == MODE_RSVD);
  assign every_edge = (mode == MODE_BOTH);
  assign wake_mode  = (mode == MODE_WAKE);
  assign presc_mode = (mode == MODE_RISE4) || (mode == MODE_RISE16);

  always_ff @(posedge clk) begin
    if (!rst_n)                 presc_q <= '0;
    else if (chan_off)          presc_q <= '0;
    else if (presc_mode && rise) presc_q <= presc_q + 1'b1;
  end

  always_comb begin
    case (mode)
      MODE_BOTH:   cap_req = rise | fall;
      MODE_FALL:   cap_req = fall;
      MODE_RISE:   cap_req = rise;
      MODE_RISE4:  cap_req = rise && (&presc_q[Q4_BITS-1:0]);
      MODE_RISE16: cap_req = rise && (&presc_q);
      default:     cap_req = 1'b0;
    endcase
  end

  // R5: a disabled channel leaves the prescaler at zero
  assert_presc_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_off |=> (presc_q == '0));
endmodule

// File: rtl/es_stamp_fifo.sv
module es_stamp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         allow_ovf,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         ovf,
  output logic         stored
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  ent_q [DEPTH];
  logic [W-1:0]  ent_d [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full, pop_fire, ovf_set;
  logic [AW-1:0] wr_idx;

  assign full     = (cnt_q == CW'(DEPTH));
  assign pop_fire = pop && (cnt_q != '0);
  assign stored   = push && !ovf_q && !flush && (!full || pop_fire);
  assign ovf_set  = push && !ovf_q && !flush && full && !pop_fire && allow_ovf;
  assign wr_idx   = pop_fire ? AW'(cnt_q - 1'b1) : AW'(cnt_q);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
    if (pop_fire)
      for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i + 1];
    if (stored) ent_d[wr_idx] = push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(stored) - CW'(pop_fire);
      if (ovf_set)
        ovf_q <= 1'b1;
      else if (ovf_q && pop_fire && cnt_q == CW'(1))
        ovf_q <= 1'b0;
    end
  end

  assign rd_data  = ent_q[0];
  assign rd_valid = (cnt_q != '0);
  assign ovf      = ovf_q;

  // R6: occupancy never exceeds the queue depth
  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R8: while locked the queue can only shrink
  assert_locked_no_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !flush) |=> (cnt_q <= $past(cnt_q)));
  // R8: the flag only rises from a full queue
  assert_ovf_from_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(cnt_q) == CW'(DEPTH)));
endmodule

// File: rtl/es_irq_ctl.sv
module es_irq_ctl #(
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_off,
  input  logic          every_edge,
  input  logic          wake_mode,
  input  logic          cap_req,
  input  logic          rise,
  input  logic          stored,
  input  logic [NW-1:0] every,
  input  logic          irq_en,
  output logic          irq_pulse,
  output logic          wake_req
);
  logic [NW-1:0] irqc_q;
  logic          hit, counting;

  assign counting = stored && !every_edge;
  assign hit      = counting && (irqc_q >= every);

  always_ff @(posedge clk) begin
    if (!rst_n || chan_off) irqc_q <= '0;
    else if (counting)      irqc_q <= hit ? '0 : irqc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      irq_pulse <= (every_edge && cap_req) || hit || (wake_mode && rise);
      wake_req  <= wake_mode && rise && irq_en;
    end
  end

  // R11: a wake request is always accompanied by an interrupt
  assert_wake_with_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> irq_pulse);
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import edge_stamp_pkg::*;
#(
  parameter int TW          = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 4,
  parameter int NW          = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_async,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_tsel,
  input  logic [NW-1:0] cfg_irq_every,
  input  logic          cfg_irq_en,
  output logic [TW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic          ovf_flag,
  output logic          irq_pulse,
  output logic          wake_req
);
  cap_mode_e     mode_e;
  logic          rise, fall;
  logic          cap_req, chan_off, every_edge, wake_mode, stored;
  logic [TW-1:0] stamp;

  assign mode_e = cap_mode_e'(cfg_mode);
  assign stamp  = cfg_tsel ? timer_a : timer_b;

  es_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .rise(rise), .fall(fall));

  es_event_gen #(.PRE_W(PRE_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .rise(rise), .fall(fall),
    .cap_req(cap_req), .chan_off(chan_off), .every_edge(every_edge),
    .wake_mode(wake_mode));

  es_stamp_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(chan_off), .push(cap_req),
    .push_data(stamp), .allow_ovf(!every_edge), .pop(rd_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .ovf(ovf_flag), .stored(stored));

  es_irq_ctl #(.NW(NW)) u_irq (
    .clk(clk), .rst_n(rst_n), .chan_off(chan_off), .every_edge(every_edge),
    .wake_mode(wake_mode), .cap_req(cap_req), .rise(rise), .stored(stored),
    .every(cfg_irq_every), .irq_en(cfg_irq_en), .irq_pulse(irq_pulse),
    .wake_req(wake_req));

  // R9: both-edges mode never raises the overflow flag
  assert_no_ovf_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b001 && !ovf_flag) |=> !ovf_flag);
  // R12: wake only from the wake mode with the enable set
  assert_wake_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(cfg_mode == 3'b111 && cfg_irq_en));
endmodule

// File: tb/tb_edge_stamp_unit.sv
`timescale 1ns/1ps
module tb_edge_stamp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_async = 1'b0;
  logic [15:0] timer_a, timer_b, rd_data;
  logic [2:0]  cfg_mode = 3'b000;
  logic        cfg_tsel = 1'b0;
  logic [1:0]  cfg_irq_every = 2'd0;
  logic        cfg_irq_en = 1'b0;
  logic        rd_valid, rd_ready = 1'b0, ovf_flag, irq_pulse, wake_req;
  logic [15:0] cyc = 16'd0;

  int n_chk = 0, n_err = 0;

  // reference model state
  logic [15:0] m_q [4];
  int          m_cnt = 0, m_irqc = 0;
  logic [3:0]  m_presc = 4'd0;
  logic        m_ovf = 1'b0, m_pin = 1'b0, m_tsel = 1'b0, m_en = 1'b0;
  logic [2:0]  m_mode = 3'd0;
  int          m_every = 0;

  function automatic logic [15:0] ta(input logic [15:0] c);
    return c * 16'd3 + 16'h0100;
  endfunction
  function automatic logic [15:0] tb(input logic [15:0] c);
    return c ^ 16'h5A5A;
  endfunction

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 16'd1;
  assign timer_a = ta(cyc);
  assign timer_b = tb(cyc);

  edge_stamp_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .timer_a(timer_a),
    .timer_b(timer_b), .cfg_mode(cfg_mode), .cfg_tsel(cfg_tsel),
    .cfg_irq_every(cfg_irq_every), .cfg_irq_en(cfg_irq_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .ovf_flag(ovf_flag),
    .irq_pulse(irq_pulse), .wake_req(wake_req));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic ts,
                         input logic [1:0] ev, input logic en);
    @(negedge clk);
    cfg_mode = m; cfg_tsel = ts; cfg_irq_every = ev; cfg_irq_en = en;
    m_mode = m; m_tsel = ts; m_every = int'(ev); m_en = en;
    if (m == 3'b000 || m == 3'b110) begin
      m_cnt = 0; m_ovf = 1'b0; m_presc = 4'd0; m_irqc = 0;
    end
    @(posedge clk);
  endtask

  task automatic drive_pin(input logic lvl, input string req);
    logic r, f, ev, st, e_irq, e_wake;
    logic [15:0] c0, val;
    @(negedge clk);
    c0 = cyc; pin_async = lvl;
    r = lvl & ~m_pin; f = ~lvl & m_pin; m_pin = lvl;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "irq before third edge", irq_pulse, 0);
    chk("R1", "valid before third edge", rd_valid, m_cnt != 0);
    @(posedge clk);
    @(negedge clk);
    case (m_mode)
      3'd1: ev = r | f;
      3'd2: ev = f;
      3'd3: ev = r;
      3'd4: ev = r && (m_presc[1:0] == 2'b11);
      3'd5: ev = r && (m_presc == 4'hF);
      default: ev = 1'b0;
    endcase
    if ((m_mode == 3'd4 || m_mode == 3'd5) && r) m_presc = m_presc + 4'd1;
    val = m_tsel ? ta(c0 + 16'd2) : tb(c0 + 16'd2);
    st = 1'b0;
    if (ev && !m_ovf) begin
      if (m_cnt < 4) begin m_q[m_cnt] = val; m_cnt++; st = 1'b1; end
      else if (m_mode != 3'd1) m_ovf = 1'b1;
    end
    e_irq = 1'b0;
    if (m_mode == 3'd1) e_irq = ev;
    else if (m_mode == 3'd7) e_irq = r;
    else if (st) begin
      if (m_irqc >= m_every) begin e_irq = 1'b1; m_irqc = 0; end
      else m_irqc++;
    end
    e_wake = (m_mode == 3'd7) && r && m_en;
    chk(req, "irq_pulse", irq_pulse, e_irq);
    chk((m_mode == 3'd7) ? "R11" : "R12", "wake_req", wake_req, e_wake);
    chk("R6", "rd_valid after edge", rd_valid, m_cnt != 0);
    chk("R8", "ovf_flag after edge", ovf_flag, m_ovf);
  endtask

  task automatic pop_one(input string req);
    @(negedge clk);
    chk("R6", "valid before pop", rd_valid, m_cnt != 0);
    if (m_cnt > 0) chk(req, "rd_data", rd_data, m_q[0]);
    rd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_ready = 1'b0;
    if (m_cnt > 0) begin
      for (int i = 0; i < 3; i++) m_q[i] = m_q[i + 1];
      m_cnt--;
      if (m_cnt == 0) m_ovf = 1'b0;
    end
    chk((m_cnt == 0) ? "R7" : "R6", "valid after pop", rd_valid, m_cnt != 0);
    chk("R8", "ovf after pop", ovf_flag, m_ovf);
  endtask

  task automatic drain(input string req);
    while (m_cnt > 0) pop_one(req);
  endtask

  task automatic pulse_rise(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      drive_pin(1'b1, req);
      drive_pin(1'b0, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", "valid after reset", rd_valid, 0);
    chk("R8", "ovf after reset", ovf_flag, 0);
    chk("R10", "irq after reset", irq_pulse, 0);
    chk("R12", "wake after reset", wake_req, 0);

    // R2 / R3: every timer choice against each plain edge mode
    for (int ts = 0; ts < 2; ts++) begin
      for (int m = 1; m <= 3; m++) begin
        set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
        set_cfg(3'(m), 1'(ts), 2'd0, 1'b0);
        for (int k = 0; k < 2; k++) begin
          drive_pin(1'b1, "R3");
          drive_pin(1'b0, "R3");
        end
        drain("R2");
        pop_one("R7");
      end
    end

    // R4: divided rising-edge modes
    set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
    set_cfg(3'b100, 1'b1, 2'd0, 1'b0);
    pulse_rise(9, "R4");
    drain("R4");
    set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
    set_cfg(3'b101, 1'b0, 2'd0, 1'b0);
    pulse_rise(17, "R4");
    drain("R4");

    // R8 / R10: overflow lock across each interrupt spacing
    for (int ev = 0; ev < 4; ev++) begin
      set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
      set_cfg(3'b011, 1'b1, 2'(ev), 1'b0);
      pulse_rise(6, "R10");
      pop_one("R8");
      pop_one("R8");
      pulse_rise(1, "R8");
      drain("R8");
      pulse_rise(2, "R10");
      drain("R8");
    end

    // R9: both-edges mode ignores spacing and never locks
    set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
    set_cfg(3'b001, 1'b0, 2'd3, 1'b0);
    pulse_rise(3, "R9");
    chk("R9", "ovf stays low", ovf_flag, 0);
    pop_one("R9");
    pulse_rise(1, "R9");
    drain("R9");

    // R5: disabling flushes the queue and the lock
    set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
    set_cfg(3'b011, 1'b0, 2'd0, 1'b0);
    pulse_rise(5, "R8");
    set_cfg(3'b110, 1'b0, 2'd0, 1'b0);
    @(negedge clk);
    chk("R5", "valid after disable", rd_valid, 0);
    chk("R5", "ovf after disable", ovf_flag, 0);
    // R5: prescaler restarts after disable
    set_cfg(3'b100, 1'b0, 2'd0, 1'b0);
    pulse_rise(2, "R5");
    set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
    set_cfg(3'b100, 1'b0, 2'd0, 1'b0);
    pulse_rise(4, "R5");
    drain("R5");

    // R11 / R12: wake mode and its enable
    set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
    set_cfg(3'b111, 1'b0, 2'd0, 1'b1);
    pulse_rise(2, "R11");
    chk("R11", "nothing stored", rd_valid, 0);
    set_cfg(3'b111, 1'b0, 2'd0, 1'b0);
    pulse_rise(1, "R11");
    set_cfg(3'b000, 1'b0, 2'd0, 1'b0);
    set_cfg(3'b011, 1'b0, 2'd0, 1'b1);
    pulse_rise(2, "R12");
    drain("R12");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule